// File: doc/BRIEF.md
# RS Symbol Error Applier

This block takes a short list of error reports from a Reed-Solomon decoder and patches them into a sector buffer. The buffer sits in a byte-wide RAM that the block reaches through a single read/write port. The buffer is seen as a packed stream of 9-bit symbols. A symbol usually spans two neighbouring bytes. Each report gives a 1-based symbol index and a 9-bit error pattern. The block turns the index into a byte address and a bit offset. It then does a two-byte read-modify-write that flips the reported bits.

Before any patching, the block checks whether the sector is simply unprogrammed. This is the case when every parity byte and every data byte reads 0xFF. An unprogrammed sector is left untouched and reported as erased. When the decoder marks the sector as beyond repair, the block passes that flag through and writes nothing. A one-cycle done pulse ends every run, and the number of corrections applied is shown alongside it.

Top module: `rs_sym_fixer`

## Requirements
- R1: For an error word with index i (1 to 512), take k = i - 1. The low byte address is k + (k >> 3), and the high byte is the next address. The bit offset is k & 7. The two bytes form a little-endian 16-bit pair {high, low}. Pair bits [offset+8 : offset] are XORed with the 9-bit mask, with mask bit 0 at the lowest position.
- R2: Error word j sits at bits [19j+18 : 19j] of `err_words`. Its index is in bits [18:9] and its mask in bits [8:0]. A word with index 0, or with index above 512, causes no RAM write and is not counted.
- R3: Only the first min(`err_cnt`, 4) words are processed. An `err_cnt` above 4 is treated as 4, and words past the count are never applied.
- R4: If `uncorr_in` is high at start, no RAM access takes place. `done` pulses with `uncorr_out` = 1 and `fixed_cnt` = 0.
- R5: If all 9 parity bytes (`par_bytes`, byte p at bits [8p+7:8p]) and data bytes 0 to 511 read 0xFF, nothing is written. `done` then shows `erased` = 1 and `fixed_cnt` = 0.
- R6: If any parity byte or any data byte is not 0xFF, the sector is not erased. The corrections are applied and `erased` reads 0.
- R7: Each correction accesses the RAM in a fixed order: read low, read high, write low, write high. Read data returns on `ram_rdata` one cycle after `ram_rd`. A byte is written only after it has been read in the same run.
- R8: A high byte whose address is at or beyond `BUF_BYTES` is neither read nor written. The flipped bits that would land there are dropped, and the correction still counts.
- R9: `done` is high for exactly one cycle after the last correction. During that cycle `fixed_cnt` holds the number of corrections applied.
- R10: A `start` that arrives while a run is in progress is ignored.
- R11: While reset is held, `done`, `ram_rd` and `ram_wr` are low.
- R12: The erased check first reads data bytes 0, 256 and 511, in that order. On the first byte that is not 0xFF it stops scanning and moves straight to correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled when idle) |
| err_cnt | input | 3 | Number of error words reported |
| uncorr_in | input | 1 | Decoder marks the sector uncorrectable |
| err_words | input | 76 | Four packed error words, each {index[9:0], mask[8:0]} |
| par_bytes | input | 72 | The nine parity bytes read with the sector |
| ram_addr | output | 10 | Buffer RAM byte address |
| ram_rd | output | 1 | Buffer RAM read strobe |
| ram_wr | output | 1 | Buffer RAM write strobe |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_rdata | input | 8 | Buffer RAM read data, one cycle after ram_rd |
| done | output | 1 | One-cycle end-of-run pulse |
| erased | output | 1 | Sector found unprogrammed |
| uncorr_out | output | 1 | Uncorrectable flag passed through |
| fixed_cnt | output | 3 | Corrections applied in the last run |

## Verification
The vector table runs the patcher with several kinds of error lists. Single symbols at bit offsets 0, 3 and 7 show whether bits cross into the high byte correctly. Overlapping symbols in neighbouring bytes test that successive read-modify-writes build on each other. Invalid indices (0 and 513) mixed with valid ones, and counts above and below the number of words supplied, separate skipped entries from applied ones. Erased-sector cases differ only in where the first non-0xFF byte sits (a probe byte, a byte found only by the full scan, or the parity), which exposes both the early exit and the full scan. A symbol at the last index, with the buffer made one byte short, shows that the high byte out of range is never touched.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PROBE, S_SCAN, S_DRAIN, S_FETCH,
    S_RLO, S_RHI, S_WLO, S_WHI, S_DONE
  } rsf_state_e;
endpackage

// File: rtl/rsf_sym_map.sv
module rsf_sym_map #(
  parameter int NSYM      = 512,
  parameter int BUF_BYTES = 576,
  parameter int IDXW      = 10,
  parameter int AW        = 10
) (
  input  logic [IDXW-1:0] idx1,
  output logic            ok,
  output logic [AW-1:0]   lo_addr,
  output logic [2:0]      bit_off,
  output logic            hi_ok
);
  logic [IDXW-1:0] k;
  logic [AW:0]     lo_ext;

  always_comb begin
    ok      = (idx1 != '0) && (idx1 <= IDXW'(NSYM));
    k       = idx1 - IDXW'(1);
    lo_ext  = (AW+1)'(k) + (AW+1)'(k >> 3);
    lo_addr = lo_ext[AW-1:0];
    bit_off = k[2:0];
    hi_ok   = (lo_ext + (AW+1)'(1)) < (AW+1)'(BUF_BYTES);
  end
endmodule

// File: rtl/rsf_patch.sv
module rsf_patch #(
  parameter int SYM_W = 9
) (
  input  logic [7:0]       lo_in,
  input  logic [7:0]       hi_in,
  input  logic [SYM_W-1:0] mask,
  input  logic [2:0]       off,
  output logic [7:0]       lo_out,
  output logic [7:0]       hi_out
);
  logic [15:0] flip, pair;

  always_comb begin
    flip   = 16'(mask) << off;
    pair   = {hi_in, lo_in} ^ flip;
    lo_out = pair[7:0];
    hi_out = pair[15:8];
  end
endmodule

// File: rtl/rsf_ff_detect.sv
module rsf_ff_detect #(
  parameter int NBYTES = 9
) (
  input  logic [NBYTES*8-1:0] bytes_in,
  output logic                all_ff
);
  logic [NBYTES-1:0] hit;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign hit[g] = (bytes_in[g*8 +: 8] == 8'hFF);
  end

  assign all_ff = &hit;
endmodule

// File: rtl/rs_sym_fixer.sv
module rs_sym_fixer
  import rsf_pkg::*;
#(
  parameter int NSYM       = 512,
  parameter int DATA_BYTES = 512,
  parameter int BUF_BYTES  = 576,
  parameter int MAX_ERR    = 4,
  parameter int PAR_BYTES  = 9,
  parameter int SYM_W      = 9,
  localparam int IDXW      = $clog2(NSYM + 1),
  localparam int WORD_W    = IDXW + SYM_W,
  localparam int CW        = $clog2(MAX_ERR + 1),
  localparam int AW        = $clog2(BUF_BYTES),
  localparam int EIW       = $clog2(MAX_ERR)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CW-1:0]            err_cnt,
  input  logic                     uncorr_in,
  input  logic [MAX_ERR*WORD_W-1:0] err_words,
  input  logic [PAR_BYTES*8-1:0]   par_bytes,
  output logic [AW-1:0]            ram_addr,
  output logic                     ram_rd,
  output logic                     ram_wr,
  output logic [7:0]               ram_wdata,
  input  logic [7:0]               ram_rdata,
  output logic                     done,
  output logic                     erased,
  output logic                     uncorr_out,
  output logic [CW-1:0]            fixed_cnt
);
  localparam logic [AW-1:0] SCAN_LAST = AW'(DATA_BYTES - 1);
  localparam logic [AW-1:0] PROBE_MID = AW'(DATA_BYTES / 2);

  rsf_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d, ei_q, ei_d, fixed_q, fixed_d;
  logic          uncorr_q, uncorr_d, erased_q, erased_d, pend_q, pend_d;
  logic [1:0]    probe_q, probe_d;
  logic [AW-1:0] scan_q, scan_d, lo_q, lo_d;
  logic [2:0]    off_q, off_d;
  logic          hiok_q, hiok_d;
  logic [MAX_ERR*WORD_W-1:0] words_q, words_d;
  logic [7:0]    lob_q, lob_d, hib_q, hib_d;

  logic [WORD_W-1:0] cur_word;
  logic [EIW-1:0]    ei_sel;
  logic              par_all_ff, map_ok, map_hiok;
  logic [AW-1:0]     map_lo, probe_addr;
  logic [2:0]        map_off;
  logic [7:0]        p_lo, p_hi, hi_src;

  assign ei_sel   = ei_q[EIW-1:0];
  assign cur_word = words_q[ei_sel*WORD_W +: WORD_W];
  assign hi_src   = hiok_q ? ram_rdata : 8'h00;
  assign probe_addr = (probe_q == 2'd0) ? '0 :
                      (probe_q == 2'd1) ? PROBE_MID : SCAN_LAST;

  rsf_ff_detect #(.NBYTES(PAR_BYTES)) u_par (
    .bytes_in(par_bytes), .all_ff(par_all_ff));

  rsf_sym_map #(.NSYM(NSYM), .BUF_BYTES(BUF_BYTES), .IDXW(IDXW), .AW(AW)) u_map (
    .idx1(cur_word[WORD_W-1:SYM_W]), .ok(map_ok), .lo_addr(map_lo),
    .bit_off(map_off), .hi_ok(map_hiok));

  rsf_patch #(.SYM_W(SYM_W)) u_patch (
    .lo_in(lob_q), .hi_in(hi_src), .mask(cur_word[SYM_W-1:0]), .off(off_q),
    .lo_out(p_lo), .hi_out(p_hi));

  // next-state and RAM port
  always_comb begin
    state_d = state_q;  cnt_d = cnt_q;     ei_d = ei_q;     fixed_d = fixed_q;
    uncorr_d = uncorr_q; erased_d = erased_q; pend_d = 1'b0;
    probe_d = probe_q;  scan_d = scan_q;   lo_d = lo_q;     off_d = off_q;
    hiok_d = hiok_q;    words_d = words_q; lob_d = lob_q;   hib_d = hib_q;
    ram_rd = 1'b0; ram_wr = 1'b0; ram_addr = '0; ram_wdata = '0;
    case (state_q)
      S_IDLE: if (start) begin
        cnt_d    = (err_cnt > CW'(MAX_ERR)) ? CW'(MAX_ERR) : err_cnt;
        words_d  = err_words;
        uncorr_d = uncorr_in;
        erased_d = 1'b0;
        fixed_d  = '0;
        ei_d     = '0;
        probe_d  = '0;
        if (uncorr_in)       state_d = S_DONE;
        else if (par_all_ff) state_d = S_PROBE;
        else                 state_d = S_FETCH;
      end
      S_PROBE, S_SCAN, S_DRAIN: begin
        if (pend_q && ram_rdata != 8'hFF) begin
          state_d = S_FETCH;
        end else if (state_q == S_PROBE) begin
          ram_rd = 1'b1; ram_addr = probe_addr; pend_d = 1'b1;
          if (probe_q == 2'd2) begin
            state_d = S_SCAN; scan_d = '0;
          end else begin
            probe_d = probe_q + 2'd1;
          end
        end else if (state_q == S_SCAN) begin
          ram_rd = 1'b1; ram_addr = scan_q; pend_d = 1'b1;
          if (scan_q == SCAN_LAST) state_d = S_DRAIN;
          else                     scan_d  = scan_q + AW'(1);
        end else begin
          erased_d = 1'b1;
          state_d  = S_DONE;
        end
      end
      S_FETCH: begin
        if (ei_q >= cnt_q) begin
          state_d = S_DONE;
        end else if (!map_ok) begin
          ei_d = ei_q + CW'(1);
        end else begin
          lo_d = map_lo; off_d = map_off; hiok_d = map_hiok;
          state_d = S_RLO;
        end
      end
      S_RLO: begin
        ram_rd = 1'b1; ram_addr = lo_q;
        state_d = S_RHI;
      end
      S_RHI: begin
        lob_d = ram_rdata;
        if (hiok_q) begin
          ram_rd = 1'b1; ram_addr = lo_q + AW'(1);
        end
        state_d = S_WLO;
      end
      S_WLO: begin
        ram_wr = 1'b1; ram_addr = lo_q; ram_wdata = p_lo;
        hib_d = p_hi;
        if (hiok_q) begin
          state_d = S_WHI;
        end else begin
          fixed_d = fixed_q + CW'(1); ei_d = ei_q + CW'(1);
          state_d = S_FETCH;
        end
      end
      S_WHI: begin
        ram_wr = 1'b1; ram_addr = lo_q + AW'(1); ram_wdata = hib_q;
        fixed_d = fixed_q + CW'(1); ei_d = ei_q + CW'(1);
        state_d = S_FETCH;
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      ei_q     <= '0;
      fixed_q  <= '0;
      uncorr_q <= 1'b0;
      erased_q <= 1'b0;
      pend_q   <= 1'b0;
      probe_q  <= '0;
      scan_q   <= '0;
      lo_q     <= '0;
      off_q    <= '0;
      hiok_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      ei_q     <= ei_d;
      fixed_q  <= fixed_d;
      uncorr_q <= uncorr_d;
      erased_q <= erased_d;
      pend_q   <= pend_d;
      probe_q  <= probe_d;
      scan_q   <= scan_d;
      lo_q     <= lo_d;
      off_q    <= off_d;
      hiok_q   <= hiok_d;
    end
  end

  // data registers, no reset
  always_ff @(posedge clk) begin
    if (state_q == S_IDLE && start) words_q <= words_d;
    if (state_q == S_RHI)           lob_q   <= lob_d;
    if (state_q == S_WLO)           hib_q   <= hib_d;
  end

  assign done       = (state_q == S_DONE);
  assign erased     = erased_q;
  assign uncorr_out = uncorr_q;
  assign fixed_cnt  = fixed_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_uncorr_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorr_q && state_q != S_IDLE) |-> !ram_wr);
  assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd || ram_wr) |-> (ram_addr < AW'(BUF_BYTES)));
  assert_wlo_after_rhi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WLO) |-> ($past(state_q) == S_RHI));
  assert_no_rd_wr_clash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_rd && ram_wr));
  assert_erased_zero_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && erased) |-> (fixed_cnt == '0));
  assert_fix_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fixed_cnt <= cnt_q));
  assert_busy_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && start) |=> $stable(cnt_q));
endmodule

// File: tb/sim_rs_sym_fixer.sv
module sim_rs_sym_fixer;
  localparam int CLK_NS = 10;
  localparam int BUFB   = 575;

  typedef struct packed {
    logic [1:0]       fill;
    logic             parff;
    logic             unc;
    logic [2:0]       cnt;
    logic [3:0][18:0] w;
    logic [2:0]       xfix;
    logic             xers;
  } vec_t;

  localparam logic [18:0] Z = '0;
  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd1,1'b0,1'b0,3'd1,{Z,Z,Z,{10'd1,9'h1FF}},3'd1,1'b0},
    '{2'd1,1'b0,1'b0,3'd2,{Z,Z,{10'd100,9'h100},{10'd12,9'h0A5}},3'd2,1'b0},
    '{2'd1,1'b0,1'b0,3'd4,{{10'd64,9'h155},{10'd513,9'h1FF},{10'd0,9'h1FF},{10'd8,9'h1FF}},3'd2,1'b0},
    '{2'd1,1'b0,1'b0,3'd6,{{10'd5,9'h008},{10'd4,9'h004},{10'd3,9'h002},{10'd2,9'h001}},3'd4,1'b0},
    '{2'd1,1'b0,1'b0,3'd2,{{10'd40,9'h0F0},{10'd30,9'h00F},{10'd20,9'h111},{10'd10,9'h1FF}},3'd2,1'b0},
    '{2'd1,1'b0,1'b1,3'd2,{Z,Z,{10'd6,9'h1FF},{10'd5,9'h1FF}},3'd0,1'b0},
    '{2'd0,1'b1,1'b0,3'd2,{Z,Z,{10'd6,9'h1FF},{10'd5,9'h1FF}},3'd0,1'b1},
    '{2'd2,1'b1,1'b0,3'd1,{Z,Z,Z,{10'd50,9'h0C3}},3'd1,1'b0},
    '{2'd0,1'b0,1'b0,3'd1,{Z,Z,Z,{10'd200,9'h1AB}},3'd1,1'b0},
    '{2'd3,1'b1,1'b0,3'd1,{Z,Z,Z,{10'd300,9'h077}},3'd1,1'b0},
    '{2'd1,1'b0,1'b0,3'd1,{Z,Z,Z,{10'd512,9'h1FF}},3'd1,1'b0},
    '{2'd1,1'b0,1'b0,3'd0,{Z,Z,Z,{10'd7,9'h1FF}},3'd0,1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, uncorr_in = 1'b0;
  logic [2:0]  err_cnt = '0;
  logic [75:0] err_words = '0;
  logic [71:0] par_bytes = '1;
  logic [9:0]  ram_addr;
  logic        ram_rd, ram_wr, done, erased, uncorr_out;
  logic [7:0]  ram_wdata, ram_rdata;
  logic [2:0]  fixed_cnt;

  logic [7:0] mem [0:575];
  logic [7:0] exp_m [0:575];
  logic       rd_seen [0:575];
  int nrd, nwr, oob, order_err, ndone;
  int rdlog [0:3];
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  rs_sym_fixer #(.BUF_BYTES(BUFB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .err_cnt(err_cnt),
    .uncorr_in(uncorr_in), .err_words(err_words), .par_bytes(par_bytes),
    .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .done(done),
    .erased(erased), .uncorr_out(uncorr_out), .fixed_cnt(fixed_cnt));

  // buffer RAM model with one cycle read latency, plus access log
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (done) ndone = ndone + 1;
    if (ram_rd) begin
      ram_rdata <= mem[ram_addr];
      if (int'(ram_addr) >= BUFB) oob = oob + 1;
      else rd_seen[ram_addr] = 1'b1;
      if (nrd < 4) rdlog[nrd] = int'(ram_addr);
      nrd = nrd + 1;
    end
    if (ram_wr) begin
      if (int'(ram_addr) >= BUFB) oob = oob + 1;
      else begin
        if (!rd_seen[ram_addr]) order_err = order_err + 1;
        mem[ram_addr] = ram_wdata;
      end
      nwr = nwr + 1;
    end
  end

  initial begin
    wait (cyc > 150000);
    fails = fails + 1;
    $display("FAIL watchdog: got cycle %0d exp below 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input int got, input int expv);
    checks = checks + 1;
    if (got != expv) begin
      fails = fails + 1;
      $display("FAIL %s: got %0d exp %0d", tag, got, expv);
    end
  endtask

  task automatic fill_buf(input logic [1:0] f);
    for (int i = 0; i < 576; i++) begin
      mem[i] = (f == 2'd1) ? 8'((i * 7 + 3) & 255) : 8'hFF;
      rd_seen[i] = 1'b0;
    end
    if (f == 2'd2) mem[300] = 8'hFE;
    if (f == 2'd3) mem[256] = 8'h00;
    for (int i = 0; i < 576; i++) exp_m[i] = mem[i];
  endtask

  // expected buffer from R1/R2/R3/R8, bit by bit
  task automatic model(input vec_t v, input logic skip);
    int n, idx, k, lo, bp, a;
    n = (v.cnt > 4) ? 4 : int'(v.cnt);
    if (skip) return;
    for (int j = 0; j < n; j++) begin
      idx = int'(v.w[j][18:9]);
      if (idx >= 1 && idx <= 512) begin
        k  = idx - 1;
        lo = k + k / 8;
        for (int b = 0; b < 9; b++) begin
          bp = (k % 8) + b;
          a  = lo + bp / 8;
          if (a < BUFB) exp_m[a][bp % 8] = exp_m[a][bp % 8] ^ v.w[j][b];
        end
      end
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    err_cnt = v.cnt; uncorr_in = v.unc; err_words = v.w;
    par_bytes = v.parff ? {72{1'b1}} : {8'h12, {64{1'b1}}};
    nrd = 0; nwr = 0; oob = 0; order_err = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic compare_buf(input string tag);
    int bad = 0;
    for (int i = 0; i < BUFB; i++) if (mem[i] !== exp_m[i]) bad++;
    chk(tag, bad, 0);
  endtask

  initial begin
    ndone = 0; nrd = 0; nwr = 0; oob = 0; order_err = 0;
    fill_buf(2'd1);
    repeat (3) @(negedge clk);
    chk("R11 done in reset", int'(done), 0);
    chk("R11 rd in reset", int'(ram_rd), 0);
    chk("R11 wr in reset", int'(ram_wr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      logic skip;
      v = TBL[n];
      skip = v.unc || (v.parff && v.fill == 2'd0);
      fill_buf(v.fill);
      model(v, skip);
      launch(v);
      wait_done();
      $display("vector %0d", n);
      chk("R9 done seen", int'(done), 1);
      chk("R3 R9 fixed_cnt", int'(fixed_cnt), int'(v.xfix));
      chk("R5 R6 erased", int'(erased), int'(v.xers));
      chk("R4 uncorr_out", int'(uncorr_out), int'(v.unc));
      chk("R8 out of range access", oob, 0);
      chk("R7 write before read", order_err, 0);
      @(negedge clk);
      chk("R9 done one cycle", int'(done), 0);
      compare_buf("R1 R2 buffer");
      if (v.unc) chk("R4 no access", nrd + nwr, 0);
      if (skip && !v.unc) chk("R5 no write", nwr, 0);
      if (n == 7) begin
        chk("R12 probe third", rdlog[2], 511);
        chk("R12 scan begins", rdlog[3], 0);
      end
      if (n == 9) begin
        chk("R12 probe first", rdlog[0], 0);
        chk("R12 probe second", rdlog[1], 256);
        chk("R12 early exit", rdlog[2], 336);
      end
      if (n == 10) chk("R8 byte 574", int'(mem[574]), int'(exp_m[574]));
    end

    // R10: second start during a run has no effect
    begin
      vec_t v;
      v = '{2'd1,1'b0,1'b0,3'd1,{Z,Z,Z,{10'd9,9'h1FF}},3'd1,1'b0};
      fill_buf(2'd1);
      model(v, 1'b0);
      launch(v);
      uncorr_in = 1'b1; err_cnt = 3'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0; uncorr_in = 1'b0;
      ndone = 0;
      wait_done();
      chk("R10 fixed_cnt", int'(fixed_cnt), 1);
      chk("R10 uncorr_out", int'(uncorr_out), 0);
      repeat (20) @(negedge clk);
      chk("R10 single done", ndone, 1);
      compare_buf("R10 buffer");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule